// File: doc/BRIEF.md
# Security CPU Debug Access Gate

This block decides whether an external debugger may reach the security CPU and the protected memory areas behind it. Two control bits are involved. One is a staged option bit that normally comes from non-volatile storage. The other is a software enable bit. A global security state input decides who may change each bit. The debug enable output is high only when both the option and the software bit permit debug. When that output is low, the debugger reaches neither the security CPU nor any secure area.

Write requests come from either the host CPU or the security CPU. Each request carries a tag for which CPU sent it and whether the access was secure. The block checks every request against the permission rules for the current security state. It accepts or rejects the request in the cycle it arrives.

An accepted option write lands only in a shadow register. The effective option follows the shadow only when an option-load restart pulse arrives. A fall of the security state also stages a debug disable in the shadow.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: After reset, the shadow option and the effective option both read 1 (debug permitted), the software bit reads 1, `dbg_en_o` is 1 and `wr_err_o` is 0.
- R2: `dbg_en_o` equals the effective option AND the effective software bit. While the effective option is 0, `dbg_en_o` stays 0 whatever the software bit holds.
- R3: While `sec_state_i` is 0, an option write (`wr_sel_i`=0) from either CPU, with either attribute, is accepted. It loads `wr_val_i` into the shadow and raises no error.
- R4: While `sec_state_i` is 0, `sw_eff_o` reads 1. Every software-bit write (`wr_sel_i`=1) in this state is rejected.
- R5: While `sec_state_i` is 1, a software-bit write of any value is accepted only from the security CPU (`wr_src_i`=1) with `wr_sec_i`=1. An option write of 1 is accepted under the same condition. `sw_eff_o` then shows the stored software bit.
- R6: While `sec_state_i` is 1, the security CPU may write 0 to the option with either attribute. Every host write (`wr_src_i`=0) in this state is rejected.
- R7: On a cycle where `sec_state_i` goes from 1 to 0, the shadow option is set to 0. This takes priority over an option write in the same cycle. The effective option is unchanged until the next load pulse.
- R8: The effective option changes only on a cycle with `obl_i` high, where it takes the value the shadow held before that edge.
- R9: A rejected write changes no state. It raises `wr_err_o` for exactly the one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_state_i | input | 1 | Global security state, 1 = secure |
| obl_i | input | 1 | Option-load restart pulse |
| wr_en_i | input | 1 | Write request valid |
| wr_sel_i | input | 1 | Target: 0 = option bit, 1 = software bit |
| wr_val_i | input | 1 | Written value, 1 = permit debug |
| wr_src_i | input | 1 | Requester: 0 = host CPU, 1 = security CPU |
| wr_sec_i | input | 1 | Secure attribute of the request |
| opt_shadow_o | output | 1 | Staged option value |
| opt_eff_o | output | 1 | Effective option value |
| sw_eff_o | output | 1 | Effective software enable |
| dbg_en_o | output | 1 | Debugger access enable |
| wr_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The bench checks that an option write never moves the effective value before a load pulse. A design that skipped the shadow would change debug access at once. It checks the asymmetric secure-state rules: a non-secure-attributed write from the security CPU may disable debug but may not enable it. A design that treated enable and disable alike would let that access re-open debug. It checks that a software bit of 1 cannot re-open debug while the option forbids it. It also checks that a security drop in the same cycle as a host option write still stages a disable. A design with the wrong priority would leave debug permitted after the next load.

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl #(
  parameter bit OPT_RST = 1'b1,
  parameter bit SW_RST  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_state_i,
  input  logic obl_i,
  input  logic wr_en_i,
  input  logic wr_sel_i,
  input  logic wr_val_i,
  input  logic wr_src_i,
  input  logic wr_sec_i,
  output logic opt_shadow_o,
  output logic opt_eff_o,
  output logic sw_eff_o,
  output logic dbg_en_o,
  output logic wr_err_o
);
  localparam logic SEL_OPT = 1'b0;
  localparam logic SEL_SW  = 1'b1;
  localparam logic SRC_SEC = 1'b1;

  logic shadow_q, eff_q, sw_q, err_q, sec_q;
  logic accept, sec_fall;

  always_comb begin
    if (!sec_state_i)
      accept = (wr_sel_i == SEL_OPT);
    else if (wr_sel_i == SEL_OPT)
      accept = (wr_src_i == SRC_SEC) && (wr_sec_i || !wr_val_i);
    else
      accept = (wr_src_i == SRC_SEC) && wr_sec_i;
  end

  assign sec_fall = sec_q & ~sec_state_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= OPT_RST;
      eff_q    <= OPT_RST;
      sw_q     <= SW_RST;
      err_q    <= 1'b0;
      sec_q    <= 1'b0;
    end else begin
      sec_q <= sec_state_i;
      err_q <= wr_en_i & ~accept;
      if (sec_fall)
        shadow_q <= 1'b0;
      else if (wr_en_i && accept && wr_sel_i == SEL_OPT)
        shadow_q <= wr_val_i;
      if (wr_en_i && accept && wr_sel_i == SEL_SW)
        sw_q <= wr_val_i;
      if (obl_i)
        eff_q <= shadow_q;
    end
  end

  assign opt_shadow_o = shadow_q;
  assign opt_eff_o    = eff_q;
  assign sw_eff_o     = sec_state_i ? sw_q : 1'b1;
  assign dbg_en_o     = eff_q & sw_eff_o;
  assign wr_err_o     = err_q;

  p_eff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !obl_i |=> $stable(opt_eff_o));

  p_host_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && sec_state_i && wr_src_i != SRC_SEC) |=> wr_err_o);

  p_ns_opt_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !sec_state_i && wr_sel_i == SEL_OPT) |=> !wr_err_o);

  p_drop_stage_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_state_i) |=> !opt_shadow_o);

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err_o |-> $past(wr_en_i));

  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_eff_o |-> !dbg_en_o);
endmodule

// File: tb/dbg_gate_ctrl_tb.sv
module dbg_gate_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_state_i = 1'b0, obl_i = 1'b0, wr_en_i = 1'b0;
  logic wr_sel_i = 1'b0, wr_val_i = 1'b0, wr_src_i = 1'b0, wr_sec_i = 1'b0;
  logic opt_shadow_o, opt_eff_o, sw_eff_o, dbg_en_o, wr_err_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbg_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sec_state_i(sec_state_i), .obl_i(obl_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_val_i(wr_val_i),
    .wr_src_i(wr_src_i), .wr_sec_i(wr_sec_i), .opt_shadow_o(opt_shadow_o),
    .opt_eff_o(opt_eff_o), .sw_eff_o(sw_eff_o), .dbg_en_o(dbg_en_o),
    .wr_err_o(wr_err_o));

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic val, input logic src, input logic sec);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_val_i = val; wr_src_i = src; wr_sec_i = sec;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic load();
    @(negedge clk); obl_i = 1'b1;
    @(negedge clk); obl_i = 1'b0;
  endtask

  task automatic set_sec(input logic v);
    @(negedge clk); sec_state_i = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(opt_shadow_o, 1'b1, "R1 shadow");
    chk(opt_eff_o, 1'b1, "R1 effective");
    chk(sw_eff_o, 1'b1, "R1 sw");
    chk(dbg_en_o, 1'b1, "R1 dbg_en");
    chk(wr_err_o, 1'b0, "R1 err");
  endtask

  task automatic t_nonsecure();
    set_sec(1'b0);
    wr(1'b0, 1'b0, 1'b0, 1'b0);
    chk(wr_err_o, 1'b0, "R3 host opt write no err");
    chk(opt_shadow_o, 1'b0, "R3 shadow took 0");
    chk(opt_eff_o, 1'b1, "R8 effective held before load");
    chk(dbg_en_o, 1'b1, "R8 dbg_en held before load");
    load();
    chk(opt_eff_o, 1'b0, "R8 effective after load");
    chk(dbg_en_o, 1'b0, "R2 dbg_en off with option off");
    wr(1'b0, 1'b1, 1'b1, 1'b0);
    chk(wr_err_o, 1'b0, "R3 sec cpu opt write no err");
    chk(opt_shadow_o, 1'b1, "R3 shadow took 1");
    load();
    chk(opt_eff_o, 1'b1, "R8 effective back to 1");
    wr(1'b1, 1'b0, 1'b1, 1'b1);
    chk(wr_err_o, 1'b1, "R4 sw write rejected");
    chk(sw_eff_o, 1'b1, "R4 sw reads 1");
    chk(dbg_en_o, 1'b1, "R4 dbg_en kept");
    @(negedge clk);
    chk(wr_err_o, 1'b0, "R9 err one cycle");
  endtask

  task automatic t_secure();
    set_sec(1'b1);
    wr(1'b0, 1'b0, 1'b0, 1'b1);
    chk(wr_err_o, 1'b1, "R6 host disable rejected");
    chk(opt_shadow_o, 1'b1, "R9 shadow unchanged");
    chk(opt_eff_o, 1'b1, "R9 effective unchanged");
    wr(1'b0, 1'b0, 1'b1, 1'b0);
    chk(wr_err_o, 1'b0, "R6 sec cpu disable accepted");
    chk(opt_shadow_o, 1'b0, "R6 shadow 0");
    load();
    chk(dbg_en_o, 1'b0, "R2 dbg_en off after load");
    wr(1'b0, 1'b1, 1'b1, 1'b0);
    chk(wr_err_o, 1'b1, "R5 non-secure attr enable rejected");
    chk(opt_shadow_o, 1'b0, "R9 shadow kept 0");
    wr(1'b0, 1'b1, 1'b0, 1'b1);
    chk(wr_err_o, 1'b1, "R6 host enable rejected");
    wr(1'b0, 1'b1, 1'b1, 1'b1);
    chk(wr_err_o, 1'b0, "R5 secure enable accepted");
    chk(opt_shadow_o, 1'b1, "R5 shadow 1");
    load();
    chk(dbg_en_o, 1'b1, "R2 dbg_en on");
    wr(1'b1, 1'b0, 1'b1, 1'b0);
    chk(wr_err_o, 1'b1, "R5 non-secure attr sw write rejected");
    chk(sw_eff_o, 1'b1, "R9 sw unchanged");
    wr(1'b1, 1'b0, 1'b1, 1'b1);
    chk(wr_err_o, 1'b0, "R5 secure sw clear accepted");
    chk(sw_eff_o, 1'b0, "R5 sw reads 0");
    chk(dbg_en_o, 1'b0, "R2 dbg_en off by sw");
    wr(1'b1, 1'b1, 1'b0, 1'b1);
    chk(wr_err_o, 1'b1, "R6 host sw write rejected");
    chk(sw_eff_o, 1'b0, "R9 sw stays 0");
    wr(1'b1, 1'b1, 1'b1, 1'b1);
    chk(sw_eff_o, 1'b1, "R5 sw set");
    chk(dbg_en_o, 1'b1, "R2 dbg_en on again");
  endtask

  task automatic t_sw_ignored();
    wr(1'b0, 1'b0, 1'b1, 1'b1);
    load();
    chk(sw_eff_o, 1'b1, "R2 sw still 1");
    chk(dbg_en_o, 1'b0, "R2 sw ignored when option off");
    wr(1'b0, 1'b1, 1'b1, 1'b1);
    load();
    chk(dbg_en_o, 1'b1, "R2 option restored");
  endtask

  task automatic t_drop();
    @(negedge clk);
    sec_state_i = 1'b0;
    wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_val_i = 1'b1; wr_src_i = 1'b0; wr_sec_i = 1'b0;
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(wr_err_o, 1'b0, "R7 same-cycle write not an error");
    chk(opt_shadow_o, 1'b0, "R7 drop stages disable");
    chk(opt_eff_o, 1'b1, "R7 effective held until load");
    load();
    chk(opt_eff_o, 1'b0, "R7 disable after load");
    chk(dbg_en_o, 1'b0, "R7 dbg_en off after load");
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nonsecure();
    t_secure();
    t_sw_ignored();
    t_drop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule